// File: doc/BRIEF.md
# PLL Control Register Bank

This block is the byte-wide register bank that software uses to drive a clock-generation PLL. One control register carries the interrupt enable, a sticky lock-change flag, the PLL power switch, the base-clock select and a two-bit VCO power-of-two range. Next to it sit a multiplier register, a VCO range-select register and a read-only status register that shows the lock state. The analog loop, the VCO and the clock multiplexer are outside the block. They take their settings from the block's outputs and send back a lock indication.

The bits lock each other. The manual/automatic mode input gates the interrupt enable, the flag and the lock readback. The base-clock select can be set only while the PLL is powered and the range select is non-zero. While the base-clock select is set, the PLL cannot be switched off. While the PLL is powered, its programming registers are frozen. The lock input passes through a synchronizer. Every change of the synchronized lock sets the flag. A read of the control register clears the flag.

Top module: `pll_ctl_regs`

## Requirements
- R1: After reset the control register (address 0) reads 0x20, the multiplier register (address 1) reads 0x40, the range-select register (address 2) reads 0x40, and the interrupt request is low.
- R2: Control register bit positions are: bit 7 interrupt enable, bit 6 lock-change flag, bit 5 PLL on, bit 4 base-clock select, bits 1:0 VCO range. Bits 3:2 read 0 and ignore writes.
- R3: Each change of the lock input, rising or falling, sets the flag. The set takes effect three clock edges after the change: two synchronizer flops and one edge stage.
- R4: A read of the control register returns the flag as it was before the read and clears it at that clock edge. If a synchronized lock change lands in the same cycle as the read, the flag stays set.
- R5: The interrupt request is high exactly while the flag, the interrupt enable and the automatic mode input are all 1.
- R6: While the automatic mode input is 0, the interrupt enable and the flag are held at 0 and read 0. Writes to the enable are ignored, and the lock bit of the status register reads 0.
- R7: While PLL on is 0, or while the range-select register is 0x00, the base-clock select is held at 0 and writes to it are ignored.
- R8: While the base-clock select is 1, PLL on stays 1 and writes of 0 to it are ignored.
- R9: While PLL on is 1, writes to the multiplier and range-select registers are ignored. While PLL on is 0, these writes take effect.
- R10: The status register (address 3) returns the synchronized lock in bit 7, gated by the automatic mode input, with its other bits 0. Addresses 4 to 7 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; a read of address 0 clears the flag |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from the current state |
| lock_in | input | 1 | Asynchronous lock indication from the PLL |
| auto_mode | input | 1 | Automatic mode select; 0 gates enable, flag and lock readback |
| irq | output | 1 | Interrupt request |
| pll_on | output | 1 | PLL power switch |
| base_clk_sel | output | 1 | Base clock source select |
| vco_range | output | 2 | VCO power-of-two range |
| mult | output | 8 | Multiplier setting |
| vrs_sel | output | 8 | VCO range-select setting |

## Verification
The hardest case to reach is a control-register read that lands in the same cycle as a synchronized lock change. Because of the pipeline delay, the lock input must toggle exactly three edges before the read. The bench places the toggle there on purpose and then checks that the flag stays set. The other hard path goes through the range-select register being zero while the PLL is powered. To reach it, the stimulus switches the PLL off, writes 0x00 to the range select, switches the PLL back on and then tries to set the base-clock select. Random traffic then mixes lock toggles, mode changes and writes to all eight addresses.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;

    localparam int unsigned DW = 8;
    localparam int unsigned AW = 3;

    localparam logic [AW-1:0] ADDR_CTL  = 3'd0;
    localparam logic [AW-1:0] ADDR_MUL  = 3'd1;
    localparam logic [AW-1:0] ADDR_VRS  = 3'd2;
    localparam logic [AW-1:0] ADDR_STAT = 3'd3;

    // bit positions inside the control register
    localparam int unsigned B_IE   = 7;
    localparam int unsigned B_FLAG = 6;
    localparam int unsigned B_ON   = 5;
    localparam int unsigned B_BCS  = 4;

    typedef struct packed {
        logic          ie;
        logic          flag;
        logic          on;
        logic          bcs;
        logic [1:0]    rng;
        logic [DW-1:0] mul;
        logic [DW-1:0] vrs;
    } regs_t;

    localparam regs_t REGS_RST = '{
        ie:   1'b0,
        flag: 1'b0,
        on:   1'b1,
        bcs:  1'b0,
        rng:  2'b00,
        mul:  8'h40,
        vrs:  8'h40
    };

endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_async,
    output logic lock_sync,
    output logic lock_edge
);
    logic [STAGES-1:0] sh_d, sh_q;
    logic              prev_d, prev_q;

    assign sh_d[0] = lock_async;
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        assign sh_d[i] = sh_q[i-1];
    end
    assign prev_d = sh_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= sh_d;
            prev_q <= prev_d;
        end
    end

    assign lock_sync = sh_q[STAGES-1];
    assign lock_edge = sh_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/pll_ctl_rdmux.sv
module pll_ctl_rdmux
    import pll_ctl_pkg::*;
(
    input  regs_t         regs,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic          auto_mode,
    input  logic          lock_sync,
    output logic [DW-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (addr)
                ADDR_CTL: begin
                    rd_data[B_IE]   = regs.ie & auto_mode;
                    rd_data[B_FLAG] = regs.flag & auto_mode;
                    rd_data[B_ON]   = regs.on;
                    rd_data[B_BCS]  = regs.bcs;
                    rd_data[1:0]    = regs.rng;
                end
                ADDR_MUL:  rd_data = regs.mul;
                ADDR_VRS:  rd_data = regs.vrs;
                ADDR_STAT: rd_data[DW-1] = lock_sync & auto_mode;
                default:   rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
    import pll_ctl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          lock_in,
    input  logic          auto_mode,
    output logic          irq,
    output logic          pll_on,
    output logic          base_clk_sel,
    output logic [1:0]    vco_range,
    output logic [DW-1:0] mult,
    output logic [DW-1:0] vrs_sel
);
    regs_t regs_d, regs_q;
    logic  lock_sync, lock_edge;
    logic  wr_ctl, wr_mul, wr_vrs, rd_ctl;

    pll_lock_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_async (lock_in),
        .lock_sync  (lock_sync),
        .lock_edge  (lock_edge)
    );

    assign wr_ctl = wr_en && (addr == ADDR_CTL);
    assign wr_mul = wr_en && (addr == ADDR_MUL);
    assign wr_vrs = wr_en && (addr == ADDR_VRS);
    assign rd_ctl = rd_en && (addr == ADDR_CTL);

    always_comb begin
        regs_d = regs_q;

        // interrupt enable: only alive in automatic mode
        if (!auto_mode)  regs_d.ie = 1'b0;
        else if (wr_ctl) regs_d.ie = wr_data[B_IE];

        // lock-change flag: set wins over read-clear
        if (!auto_mode)     regs_d.flag = 1'b0;
        else if (lock_edge) regs_d.flag = 1'b1;
        else if (rd_ctl)    regs_d.flag = 1'b0;

        // power switch is pinned while the base clock is selected
        if (regs_q.bcs)  regs_d.on = 1'b1;
        else if (wr_ctl) regs_d.on = wr_data[B_ON];

        // base clock select needs a powered PLL and a non-zero range
        if (!regs_d.on || (regs_q.vrs == '0)) regs_d.bcs = 1'b0;
        else if (wr_ctl)                      regs_d.bcs = wr_data[B_BCS];

        if (wr_ctl) regs_d.rng = wr_data[1:0];

        // programming registers are frozen while the PLL runs
        if (!regs_q.on) begin
            if (wr_mul) regs_d.mul = wr_data;
            if (wr_vrs) regs_d.vrs = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    pll_ctl_rdmux i_rdmux (
        .regs      (regs_q),
        .addr      (addr),
        .rd_en     (rd_en),
        .auto_mode (auto_mode),
        .lock_sync (lock_sync),
        .rd_data   (rd_data)
    );

    assign irq          = regs_q.flag & regs_q.ie & auto_mode;
    assign pll_on       = regs_q.on;
    assign base_clk_sel = regs_q.bcs;
    assign vco_range    = regs_q.rng;
    assign mult         = regs_q.mul;
    assign vrs_sel      = regs_q.vrs;
endmodule

// File: rtl/pll_ctl_regs_chk.sv
module pll_ctl_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic       auto_mode,
    input logic       irq,
    input logic       pll_on,
    input logic       base_clk_sel,
    input logic [7:0] mult,
    input logic [7:0] vrs_sel,
    input logic [7:0] rd_data,
    input logic       lock_edge,
    input logic       flag_q
);
    a_r8_bcs_keeps_on: assert property (@(posedge clk) disable iff (!rst_n)
        base_clk_sel |-> pll_on);

    a_r7_bcs_needs_range: assert property (@(posedge clk) disable iff (!rst_n)
        base_clk_sel |-> (vrs_sel != 8'h00));

    a_r9_prog_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_on && wr_en && (addr == 3'd1 || addr == 3'd2))
            |=> ($stable(mult) && $stable(vrs_sel)));

    a_r6_no_irq_manual: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_mode |-> !irq);

    a_r3_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && lock_edge) |=> flag_q);

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd0 && !lock_edge) |=> !flag_q);

    a_r10_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[2]) |-> (rd_data == 8'h00));
endmodule

bind pll_ctl_regs pll_ctl_regs_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .auto_mode    (auto_mode),
    .irq          (irq),
    .pll_on       (pll_on),
    .base_clk_sel (base_clk_sel),
    .mult         (mult),
    .vrs_sel      (vrs_sel),
    .rd_data      (rd_data),
    .lock_edge    (lock_edge),
    .flag_q       (regs_q.flag)
);

// File: tb/test_pll_ctl_regs.sv
`timescale 1ns/1ps
module test_pll_ctl_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       lock_in = 1'b0, auto_mode = 1'b1;
    logic       irq, pll_on, base_clk_sel;
    logic [1:0] vco_range;
    logic [7:0] mult, vrs_sel;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pll_ctl_regs i_pll_ctl_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .lock_in(lock_in),
        .auto_mode(auto_mode), .irq(irq), .pll_on(pll_on),
        .base_clk_sel(base_clk_sel), .vco_range(vco_range), .mult(mult),
        .vrs_sel(vrs_sel)
    );

    // reference model state
    bit m_s1, m_s2, m_p, m_ie, m_flag, m_on, m_bcs;
    bit [1:0] m_rng;
    bit [7:0] m_mul, m_vrs;

    function automatic void m_reset();
        m_s1 = 0; m_s2 = 0; m_p = 0; m_ie = 0; m_flag = 0; m_on = 1; m_bcs = 0;
        m_rng = 0; m_mul = 8'h40; m_vrs = 8'h40;
    endfunction

    function automatic bit [7:0] m_read(bit [2:0] a, bit au);
        case (a)
            3'd0: return {m_ie & au, m_flag & au, m_on, m_bcs, 2'b00, m_rng};
            3'd1: return m_mul;
            3'd2: return m_vrs;
            3'd3: return {m_s2 & au, 7'd0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic void m_step(bit [2:0] a, bit wr, bit rd, bit [7:0] d, bit lk, bit au);
        bit edge_s, wctl, rctl, ie_n, fl_n, on_n, bcs_n;
        bit [1:0] rng_n; bit [7:0] mul_n, vrs_n;
        edge_s = m_s2 ^ m_p;
        wctl = wr && a == 3'd0;
        rctl = rd && a == 3'd0;
        ie_n = !au ? 1'b0 : (wctl ? d[7] : m_ie);
        fl_n = !au ? 1'b0 : (edge_s ? 1'b1 : (rctl ? 1'b0 : m_flag));
        on_n = m_bcs ? 1'b1 : (wctl ? d[5] : m_on);
        bcs_n = (on_n && m_vrs != 0) ? (wctl ? d[4] : m_bcs) : 1'b0;
        rng_n = wctl ? d[1:0] : m_rng;
        mul_n = (!m_on && wr && a == 3'd1) ? d : m_mul;
        vrs_n = (!m_on && wr && a == 3'd2) ? d : m_vrs;
        m_ie = ie_n; m_flag = fl_n; m_on = on_n; m_bcs = bcs_n; m_rng = rng_n;
        m_mul = mul_n; m_vrs = vrs_n;
        m_p = m_s2; m_s2 = m_s1; m_s1 = lk;
    endfunction

    function automatic string tag_for(bit [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1, 3'd2: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // one bus cycle: drive at negedge, check combinational outputs, step model at posedge
    task automatic cyc(string tag, bit [2:0] a, bit wr, bit rd, bit [7:0] d, bit lk, bit au);
        @(negedge clk);
        addr = a; wr_en = wr; rd_en = rd; wr_data = d; lock_in = lk; auto_mode = au;
        #1;
        if (rd) check(tag == "" ? tag_for(a) : tag, rd_data, m_read(a, au));
        check("R5", {7'd0, irq}, {7'd0, m_flag & m_ie & au});
        @(posedge clk);
        m_step(a, wr, rd, d, lk, au);
    endtask

    task automatic idle(int n, bit lk, bit au);
        for (int i = 0; i < n; i++) cyc("", 3'd0, 0, 0, 8'h00, lk, au);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        bit lk;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset values
        cyc("R1", 3'd0, 0, 1, 0, 0, 1);
        cyc("R1", 3'd1, 0, 1, 0, 0, 1);
        cyc("R1", 3'd2, 0, 1, 0, 0, 1);
        check("R1", {7'd0, irq}, 8'h00);

        // R9 writes ignored while on, R2 reserved bits ignored
        cyc("R9", 3'd1, 1, 0, 8'h12, 0, 1);
        cyc("R9", 3'd1, 0, 1, 0, 0, 1);
        cyc("R2", 3'd0, 1, 0, 8'hAF, 0, 1);   // ie=1, on=1, bcs=0, rsv=11, rng=11
        cyc("R2", 3'd0, 0, 1, 0, 0, 1);

        // R3 lock toggle sets flag, R5 irq, R4 read clears
        cyc("R3", 3'd0, 0, 0, 0, 1, 1);
        idle(3, 1, 1);
        cyc("R3", 3'd0, 0, 1, 0, 1, 1);       // returns flag=1, clears
        cyc("R4", 3'd0, 0, 1, 0, 1, 1);       // now 0
        // falling edge
        idle(4, 0, 1);
        cyc("R3", 3'd3, 0, 1, 0, 0, 1);
        // R4 read collides with a sync edge: toggle three edges before read
        cyc("R4", 3'd0, 0, 1, 0, 0, 1);       // clear pending flag
        cyc("R4", 3'd0, 0, 0, 0, 1, 1);       // toggle
        cyc("R4", 3'd0, 0, 0, 0, 1, 1);
        cyc("R4", 3'd0, 0, 1, 0, 1, 1);       // edge lands with this read
        cyc("R4", 3'd0, 0, 1, 0, 1, 1);       // flag still set
        cyc("R4", 3'd0, 0, 1, 0, 1, 1);

        // R6 manual mode
        cyc("R6", 3'd0, 1, 0, 8'hA0, 0, 0);
        idle(4, 0, 0);
        cyc("R6", 3'd0, 0, 1, 0, 1, 0);
        idle(3, 1, 0);
        cyc("R6", 3'd3, 0, 1, 0, 1, 0);
        cyc("R10", 3'd3, 0, 1, 0, 1, 1);

        // R7 / R8 interlocks
        cyc("R7", 3'd0, 1, 0, 8'h10, 1, 1);   // on=0 and bcs=1 -> bcs blocked
        cyc("R7", 3'd0, 0, 1, 0, 1, 1);
        cyc("R9", 3'd2, 1, 0, 8'h00, 1, 1);   // off: range write allowed
        cyc("R9", 3'd1, 1, 0, 8'h5A, 1, 1);
        cyc("R9", 3'd1, 0, 1, 0, 1, 1);
        cyc("R7", 3'd0, 1, 0, 8'h30, 1, 1);   // on, but range 0 -> bcs blocked
        cyc("R7", 3'd0, 0, 1, 0, 1, 1);
        cyc("R7", 3'd0, 1, 0, 8'h00, 1, 1);
        cyc("R9", 3'd2, 1, 0, 8'h07, 1, 1);
        cyc("R8", 3'd0, 1, 0, 8'h30, 1, 1);   // bcs set
        cyc("R8", 3'd0, 1, 0, 8'h00, 1, 1);   // on stays, bcs cleared
        cyc("R8", 3'd0, 0, 1, 0, 1, 1);
        cyc("R8", 3'd0, 1, 0, 8'h30, 1, 1);
        cyc("R8", 3'd0, 1, 0, 8'h10, 1, 1);   // on=0 ignored while bcs
        cyc("R8", 3'd0, 0, 1, 0, 1, 1);

        // R10 unimplemented addresses
        for (int a = 4; a < 8; a++) begin
            cyc("R10", 3'(a), 1, 0, 8'hFF, 1, 1);
            cyc("R10", 3'(a), 0, 1, 0, 1, 1);
        end

        // constrained random
        void'($urandom(32'h5eed_1234));
        lk = 1;
        for (int i = 0; i < 3000; i++) begin
            bit [2:0] a; bit wr, rd, au; bit [7:0] d; int r;
            r  = $urandom % 10;
            a  = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'($urandom % 3);
            wr = (r < 4);
            rd = (r >= 4 && r < 8);
            d  = ($urandom % 8 == 0) ? 8'h00 : 8'($urandom);
            au = ($urandom % 16) != 0;
            if ($urandom % 6 == 0) lk = ~lk;
            cyc("", a, wr, rd, d, lk, au);
        end

        finish_run();
    end
endmodule